// File: doc/BRIEF.md
# Fixed-Priority Interrupt Vector Controller

This block takes the interrupt request lines of a small microcontroller, folds them into 32 priority slots and presents the winning slot to the CPU as a 16-bit vector word address. Slot 31 is the reset class and slot 30 the non-maskable class. The other slots are maskable by a global enable. Several slots are shared: one slot can collect several request lines, such as the eight pin flags of a port.

The CPU sees `irq_o` together with a stable vector and slot index. It accepts the grant by pulsing `cpu_ack_i`. The block then returns a one-cycle acknowledge on the winning slot's bit of `slot_ack_o`, which the peripherals use to clear their flags.

The block also watches instruction fetch addresses. A fetch that lands in the peripheral register space or in the unused hole raises a sticky request in the reset slot.

Top module: `irq_vector_ctrl`

## Requirements
- R1: After reset, `irq_o` is 0, `slot_ack_o` is all zeros, `prio_o` is 0 and `vec_addr_o` is 16'hFFC0.
- R2: The vector for slot s is 16'hFFC0 + 2*s, and `prio_o` equals s. Request lines map to slots as follows:
  - lines 0-3 go to slot 31;
  - lines 4-6 go to slot 30;
  - line 7 goes to slot 27;
  - line 8 goes to slot 26;
  - lines 9-11 go to slot 25;
  - line 12 goes to slot 24;
  - line 13 goes to slot 21;
  - lines 14-15 go to slot 20;
  - lines 16-23 go to slot 19;
  - lines 24-31 go to slot 18.
- R3: When several slots are pending, the slot with the highest number is granted.
- R4: A line mapped to slots 0..29 is pending only when both its bit in `line_en_i` and `gie_i` are 1.
- R5: Lines 4-6 are pending when their `line_en_i` bit is 1, whatever the value of `gie_i`.
- R6: Lines 0-3 are pending whenever they are raised, regardless of `line_en_i` and `gie_i`.
- R7: A fetch with `fetch_valid_i` high raises a request in slot 31 when its address is at or below 16'h01FF, or lies in 16'h0400..16'hBFFF. The request stays set until slot 31 is acknowledged. Other addresses raise nothing.
- R8: While `irq_o` is high and no acceptance occurs, `irq_o`, `vec_addr_o` and `prio_o` stay unchanged, even when a higher-priority request arrives.
- R9: When `cpu_ack_i` is high with `irq_o` high, in the next cycle `irq_o` is 0 and `slot_ack_o` is one-hot at the granted slot for exactly one cycle. When `cpu_ack_i` is high with `irq_o` low, it has no effect.
- R10: After an acceptance, a new grant is not made during the acknowledge cycle. If a request is still pending, `irq_o` rises again two cycles after the acceptance edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| line_req_i | input | 32 | Request flags, one per source line |
| line_en_i | input | 32 | Individual enables, one per source line |
| gie_i | input | 1 | Global enable for the maskable slots |
| fetch_valid_i | input | 1 | Instruction fetch strobe |
| fetch_addr_i | input | 16 | Instruction fetch address |
| cpu_ack_i | input | 1 | CPU accepts the presented vector |
| irq_o | output | 1 | Interrupt request to the CPU |
| vec_addr_o | output | 16 | Vector word address of the granted slot |
| prio_o | output | 5 | Granted slot index |
| slot_ack_o | output | 32 | One-cycle acknowledge to the granted slot |

## Verification
A corrupted grant register would show at once: `vec_addr_o` and `prio_o` would either disagree with the highest pending slot in the first cycle of `irq_o`, or drift while `irq_o` is held. A stuck acknowledge state shows in the cycle after acceptance, either as a missing or multi-hot `slot_ack_o` or as a re-grant arriving one cycle early. A wrongly set or cleared fetch-guard flag shows two cycles after the offending fetch, as a reset-slot grant that appears or is missing.

// File: rtl/ivc_pkg.sv
package ivc_pkg;
  localparam int unsigned NUM_LINES  = 32;
  localparam int unsigned NUM_SLOTS  = 32;
  localparam int unsigned SLOT_W     = $clog2(NUM_SLOTS);
  localparam int unsigned ADDR_W     = 16;
  localparam logic [ADDR_W-1:0] VEC_BASE = 16'hFFC0;
  localparam int unsigned RESET_SLOT = NUM_SLOTS - 1;
  localparam int unsigned NMI_SLOT   = NUM_SLOTS - 2;

  typedef enum logic [1:0] {CLS_RESET, CLS_NMI, CLS_MASK} slot_cls_e;

  // line -> slot routing
  function automatic int unsigned line_slot(int unsigned l);
    if (l < 4)       return 31;
    else if (l < 7)  return 30;
    else if (l == 7) return 27;
    else if (l == 8) return 26;
    else if (l < 12) return 25;
    else if (l == 12) return 24;
    else if (l == 13) return 21;
    else if (l < 16) return 20;
    else if (l < 24) return 19;
    else             return 18;
  endfunction

  function automatic slot_cls_e slot_cls(int unsigned s);
    if (s == RESET_SLOT)    return CLS_RESET;
    else if (s == NMI_SLOT) return CLS_NMI;
    else                    return CLS_MASK;
  endfunction
endpackage

// File: rtl/ivc_fetch_guard.sv
module ivc_fetch_guard
  import ivc_pkg::*;
#(
  parameter logic [ADDR_W-1:0] REG_TOP = 16'h01FF,
  parameter logic [ADDR_W-1:0] HOLE_LO = 16'h0400,
  parameter logic [ADDR_W-1:0] HOLE_HI = 16'hBFFF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fetch_valid_i,
  input  logic [ADDR_W-1:0] fetch_addr_i,
  input  logic              clr_i,
  output logic              bad_o
);
  logic bad_q, hit;

  assign hit = fetch_valid_i &&
               ((fetch_addr_i <= REG_TOP) ||
                (fetch_addr_i >= HOLE_LO && fetch_addr_i <= HOLE_HI));

  // set wins over clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    bad_q <= 1'b0;
    else if (hit)   bad_q <= 1'b1;
    else if (clr_i) bad_q <= 1'b0;
  end

  assign bad_o = bad_q;
endmodule

// File: rtl/ivc_line_merge.sv
module ivc_line_merge
  import ivc_pkg::*;
(
  input  logic [NUM_LINES-1:0] line_req_i,
  input  logic [NUM_LINES-1:0] line_en_i,
  input  logic                 gie_i,
  input  logic                 fetch_bad_i,
  output logic [NUM_SLOTS-1:0] slot_pend_o
);
  logic [NUM_SLOTS-1:0] raw_reset, raw_gated;

  always_comb begin
    raw_reset = '0;
    raw_gated = '0;
    for (int unsigned l = 0; l < NUM_LINES; l++) begin
      raw_reset[line_slot(l)] = raw_reset[line_slot(l)] | line_req_i[l];
      raw_gated[line_slot(l)] = raw_gated[line_slot(l)] | (line_req_i[l] & line_en_i[l]);
    end
  end

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    if (slot_cls(s) == CLS_RESET) begin : g_rst
      assign slot_pend_o[s] = raw_reset[s] | fetch_bad_i;
    end else if (slot_cls(s) == CLS_NMI) begin : g_nmi
      assign slot_pend_o[s] = raw_gated[s];
    end else begin : g_msk
      assign slot_pend_o[s] = raw_gated[s] & gie_i;
    end
  end
endmodule

// File: rtl/ivc_prio_pick.sv
module ivc_prio_pick
  import ivc_pkg::*;
(
  input  logic [NUM_SLOTS-1:0] pend_i,
  output logic                 valid_o,
  output logic [SLOT_W-1:0]    idx_o
);
  always_comb begin
    idx_o = '0;
    for (int unsigned s = 0; s < NUM_SLOTS; s++)
      if (pend_i[s]) idx_o = SLOT_W'(s);
  end
  assign valid_o = |pend_i;
endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
  import ivc_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_LINES-1:0] line_req_i,
  input  logic [NUM_LINES-1:0] line_en_i,
  input  logic                 gie_i,
  input  logic                 fetch_valid_i,
  input  logic [ADDR_W-1:0]    fetch_addr_i,
  input  logic                 cpu_ack_i,
  output logic                 irq_o,
  output logic [ADDR_W-1:0]    vec_addr_o,
  output logic [SLOT_W-1:0]    prio_o,
  output logic [NUM_SLOTS-1:0] slot_ack_o
);
  localparam int unsigned PAD_W = ADDR_W - SLOT_W - 1;

  logic                 fetch_bad, win_valid, accept, lock_q;
  logic [SLOT_W-1:0]    win_idx, prio_q;
  logic [NUM_SLOTS-1:0] pend, ack_q;

  assign accept = lock_q & cpu_ack_i;

  ivc_fetch_guard u_guard (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .fetch_valid_i (fetch_valid_i),
    .fetch_addr_i  (fetch_addr_i),
    .clr_i         (accept && prio_q == SLOT_W'(RESET_SLOT)),
    .bad_o         (fetch_bad)
  );

  ivc_line_merge u_merge (
    .line_req_i  (line_req_i),
    .line_en_i   (line_en_i),
    .gie_i       (gie_i),
    .fetch_bad_i (fetch_bad),
    .slot_pend_o (pend)
  );

  ivc_prio_pick u_pick (
    .pend_i  (pend),
    .valid_o (win_valid),
    .idx_o   (win_idx)
  );

  // grant is frozen from latch until acceptance; no re-grant in ack cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lock_q <= 1'b0;
      prio_q <= '0;
      ack_q  <= '0;
    end else begin
      ack_q <= '0;
      if (accept) begin
        lock_q        <= 1'b0;
        ack_q[prio_q] <= 1'b1;
      end else if (!lock_q && ack_q == '0 && win_valid) begin
        lock_q <= 1'b1;
        prio_q <= win_idx;
      end
    end
  end

  assign irq_o      = lock_q;
  assign prio_o     = prio_q;
  assign vec_addr_o = VEC_BASE + {{PAD_W{1'b0}}, prio_q, 1'b0};
  assign slot_ack_o = ack_q;
endmodule

// File: rtl/ivc_checker.sv
module ivc_checker
  import ivc_pkg::*;
(
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 gie_i,
  input logic                 cpu_ack_i,
  input logic                 irq_o,
  input logic [ADDR_W-1:0]    vec_addr_o,
  input logic [SLOT_W-1:0]    prio_o,
  input logic [NUM_SLOTS-1:0] slot_ack_o
);
  a_r8_hold_grant: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o && !cpu_ack_i |=> irq_o && $stable(vec_addr_o) && $stable(prio_o));

  a_r9_ack_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(slot_ack_o));

  a_r9_ack_follows_accept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o && cpu_ack_i |=> !irq_o && $countones(slot_ack_o) == 1 && slot_ack_o[$past(prio_o)]);

  a_r9_no_spurious_ack: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(irq_o && cpu_ack_i) |=> slot_ack_o == '0);

  a_r10_gap_after_ack: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|slot_ack_o) |=> !irq_o);

  a_r5_gie_low_grant: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) && !$past(gie_i) |-> prio_o >= SLOT_W'(NMI_SLOT));
endmodule

bind irq_vector_ctrl ivc_checker u_ivc_checker (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .gie_i      (gie_i),
  .cpu_ack_i  (cpu_ack_i),
  .irq_o      (irq_o),
  .vec_addr_o (vec_addr_o),
  .prio_o     (prio_o),
  .slot_ack_o (slot_ack_o)
);

// File: tb/tb_irq_vector_ctrl.sv
module tb_irq_vector_ctrl;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [31:0] line_req_i = '0, line_en_i = '0;
  logic        gie_i = 1'b0, fetch_valid_i = 1'b0, cpu_ack_i = 1'b0;
  logic [15:0] fetch_addr_i = '0;
  logic        irq_o;
  logic [15:0] vec_addr_o;
  logic [4:0]  prio_o;
  logic [31:0] slot_ack_o;

  int n_chk = 0, n_err = 0;
  bit done = 0;
  logic [31:0] rng = 32'h1234_5678;

  always #4 clk_i = ~clk_i;

  irq_vector_ctrl dut (.*);

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic int sl(int l);
    if (l < 4) return 31; if (l < 7) return 30; if (l == 7) return 27;
    if (l == 8) return 26; if (l < 12) return 25; if (l == 12) return 24;
    if (l == 13) return 21; if (l < 16) return 20; if (l < 24) return 19;
    return 18;
  endfunction

  // returns winning slot or -1
  function automatic int model(logic [31:0] rq, logic [31:0] en, logic g);
    int best = -1;
    for (int l = 0; l < 32; l++) begin
      bit p;
      if (l < 4)      p = rq[l];
      else if (l < 7) p = rq[l] & en[l];
      else            p = rq[l] & en[l] & g;
      if (p && sl(l) > best) best = sl(l);
    end
    return best;
  endfunction

  task automatic tick(); @(posedge clk_i); #1; endtask

  task automatic run_case(string tag, logic [31:0] rq, logic [31:0] en, logic g);
    int w = model(rq, en, g);
    line_req_i = rq; line_en_i = en; gie_i = g;
    tick();
    if (w < 0) begin
      chk({tag, " no grant"}, 32'(irq_o), 32'd0);
      line_req_i = '0;
      return;
    end
    chk({tag, " irq"}, 32'(irq_o), 32'd1);
    chk({tag, " R2 vec"}, 32'(vec_addr_o), 32'(16'hFFC0 + 2 * w));
    chk({tag, " R2 prio"}, 32'(prio_o), 32'(w));
    cpu_ack_i = 1'b1;
    tick();
    cpu_ack_i = 1'b0; line_req_i = '0;
    chk({tag, " R9 ack"}, slot_ack_o, 32'd1 << w);
    chk({tag, " R9 irq drop"}, 32'(irq_o), 32'd0);
    tick();
    chk({tag, " R9 ack one cycle"}, slot_ack_o, 32'd0);
  endtask

  function automatic logic [31:0] nxt(logic [31:0] x);
    x ^= x << 13; x ^= x >> 17; x ^= x << 5; return x;
  endfunction

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    #1;
    chk("R1 irq", 32'(irq_o), 0);
    chk("R1 ack", slot_ack_o, 0);
    chk("R1 vec", 32'(vec_addr_o), 32'hFFC0);
    chk("R1 prio", 32'(prio_o), 0);
    #20 rst_ni = 1'b1;
    tick();

    // R9: ack while idle is ignored
    cpu_ack_i = 1'b1; tick(); cpu_ack_i = 1'b0;
    chk("R9 idle ack", slot_ack_o, 0);
    chk("R9 idle irq", 32'(irq_o), 0);

    // single lines: R2, R4, R5, R6
    for (int l = 0; l < 32; l++)
      for (int m = 0; m < 4; m++)
        run_case($sformatf("R2 R4 R5 R6 line %0d mode %0d", l, m),
                 32'd1 << l, m[0] ? 32'hFFFF_FFFF : 32'd0, m[1]);

    // pairs: R3
    for (int a = 0; a < 32; a++)
      for (int b = a + 1; b < 32; b++)
        run_case($sformatf("R3 pair %0d %0d", a, b),
                 (32'd1 << a) | (32'd1 << b), 32'hFFFF_FFFF, 1'b1);

    // mixed patterns: R3 R4 R5
    for (int i = 0; i < 300; i++) begin
      logic [31:0] r, e;
      rng = nxt(rng); r = rng & nxt(rng ^ 32'h5a5a);
      rng = nxt(rng); e = rng;
      run_case($sformatf("R3 mix %0d", i), r, e, rng[3]);
    end

    // R7 fetch guard
    begin
      logic [15:0] adr [8] = '{16'h0000, 16'h01FF, 16'h0200, 16'h03FF,
                               16'h0400, 16'hBFFF, 16'hC000, 16'hFFFE};
      bit bad [8] = '{1, 1, 0, 0, 1, 1, 0, 0};
      for (int i = 0; i < 8; i++) begin
        fetch_valid_i = 1'b1; fetch_addr_i = adr[i];
        tick();
        fetch_valid_i = 1'b0;
        tick();
        chk($sformatf("R7 fetch %h irq", adr[i]), 32'(irq_o), 32'(bad[i]));
        if (bad[i]) begin
          chk("R7 vec", 32'(vec_addr_o), 32'hFFFE);
          tick();
          chk("R7 sticky", 32'(irq_o), 1);
          cpu_ack_i = 1'b1; tick(); cpu_ack_i = 1'b0;
          chk("R7 ack", slot_ack_o, 32'h8000_0000);
          tick(); tick();
          chk("R7 cleared", 32'(irq_o), 0);
        end
      end
    end

    // R8 hold under higher arrival, then R10 re-grant timing
    line_en_i = 32'hFFFF_FFFF; gie_i = 1'b1;
    line_req_i = 32'd1 << 24;
    tick();
    chk("R8 first vec", 32'(vec_addr_o), 32'hFFE4);
    line_req_i = (32'd1 << 24) | 32'd1;
    for (int k = 0; k < 3; k++) begin
      tick();
      chk("R8 held vec", 32'(vec_addr_o), 32'hFFE4);
      chk("R8 held irq", 32'(irq_o), 1);
    end
    cpu_ack_i = 1'b1; tick(); cpu_ack_i = 1'b0;
    chk("R9 ack slot18", slot_ack_o, 32'd1 << 18);
    tick();
    chk("R10 gap", 32'(irq_o), 0);
    tick();
    chk("R10 regrant", 32'(irq_o), 1);
    chk("R10 regrant vec", 32'(vec_addr_o), 32'hFFFE);
    line_req_i = '0;
    cpu_ack_i = 1'b1; tick(); cpu_ack_i = 1'b0;
    tick(); tick();
    chk("R10 idle", 32'(irq_o), 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule